// File: doc/BRIEF.md
# SATA Frame DMA Control Register Bank

This block sits between a processor's AXI4-Lite bus and a frame DMA engine that moves SATA frames between memory and the link. Software writes three 512-byte aligned buffer base addresses: one for outgoing frames, one for incoming non-data frames and one for incoming data frames. It also writes a control word that gives the transmit length and frame kind, and that can fire a transmit start or a datapath reset. A separate clear register lets software drop the interrupt lines and the received-frame-kind flag.

Reads and writes are decoded apart, so one offset can name a different register in each direction. Two offsets are readable. One returns the error status: the last error code reported by the datapath and a sticky flag for misaligned address writes. The other returns the received word count and the kind of the last received frame. The datapath drives done strobes, a word strobe and error reports. The block turns these into two level interrupts and the readable status.

Top module: `fis_dma_regbank`

## Requirements
- R1: After reset all address outputs, the transmit word count, the frame-kind select, the start and reset pulses and both interrupt lines are zero, and both readable registers read as zero.
- R2: A write to byte offset 0x00 sets the transmit buffer address, to 0x04 the non-data receive address, and to 0x0C the data receive address; each appears on its output one cycle after the write is accepted.
- R3: A written address has bits 8:0 forced to zero. If any of them was set, bit 8 of the error register becomes 1 and stays 1 until a control write with bit 31 set.
- R4: A write to offset 0x08 (control) drives bits 15:0 to the transmit word count output and bit 29 to the data-frame select output (1 = data frame).
- R5: A control write with bit 30 set yields a start pulse exactly one cycle long. A control write with bit 31 set yields a datapath reset pulse exactly one cycle long. Neither output is a held level.
- R6: A read of offset 0x04 returns the error code latched on the last error strobe in bits 7:0, the alignment flag in bit 8, and zero elsewhere.
- R7: A read of offset 0x0C returns the received word count in bits 23:0, which counts word strobes, and in bit 31 the kind of the last received frame (1 = non-data), loaded on each receive-done strobe.
- R8: Any write to the control offset clears the received word count, whatever its data.
- R9: The transmit-done strobe sets the host-to-device interrupt, cleared by writing 1 to bit 30 of offset 0x10. The receive-done strobe sets the device-to-host interrupt, cleared by writing 1 to bit 31 of offset 0x10.
- R10: When a done strobe and its clear arrive in the same cycle, the interrupt is set.
- R11: Writing 1 to bit 29 of offset 0x10 clears the received frame-kind bit and leaves both interrupts unchanged.
- R12: All responses are OKAY (code 0). Reads of offsets other than 0x04 and 0x0C return zero, and a write whose address bits 1:0 are nonzero changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | 5 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_bresp | output | 2 | Write response code |
| s_araddr | input | 5 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response code |
| tx_addr_o | output | 32 | Transmit buffer base |
| rx_fis_addr_o | output | 32 | Non-data receive buffer base |
| rx_data_addr_o | output | 32 | Data receive buffer base |
| tx_words_o | output | 16 | Transmit word count |
| tx_is_data_o | output | 1 | Transmit frame is a data frame |
| start_o | output | 1 | One-cycle transmit start |
| dp_reset_o | output | 1 | One-cycle datapath reset |
| irq_h2d_o | output | 1 | Transmit-done interrupt |
| irq_d2h_o | output | 1 | Receive-done interrupt |
| tx_done_i | input | 1 | Transmit-done strobe |
| rx_done_i | input | 1 | Receive-done strobe |
| rx_nondata_i | input | 1 | Kind of the frame finishing with rx_done_i |
| rx_word_i | input | 1 | One received word |
| err_valid_i | input | 1 | Error code strobe |
| err_code_i | input | 8 | Error code |

## Verification
The hardest case to reach is a done strobe landing in the very cycle its clear write is accepted, because the bus handshake sets that cycle. The bench's write task can raise a done strobe together with the write valids. Both meet the same accepting edge, and the interrupt is then read back at the port. The sticky alignment flag is driven through its whole cycle of set, hold over later good writes, and clear by reset-bit control write, all observed through reads of the error offset.

// File: rtl/fisreg_pkg.sv
package fisreg_pkg;
  // word indices (byte offset / 4); write and read maps differ
  localparam int unsigned IDX_TX_ADDR   = 0;
  localparam int unsigned IDX_RX_FIS    = 1;
  localparam int unsigned IDX_CTRL      = 2;
  localparam int unsigned IDX_RX_DATA   = 3;
  localparam int unsigned IDX_CLEAR     = 4;
  localparam int unsigned IDX_RD_ERR    = 1;
  localparam int unsigned IDX_RD_COUNT  = 3;

  // control word bit positions
  localparam int unsigned CTL_RESET_BIT = 31;
  localparam int unsigned CTL_START_BIT = 30;
  localparam int unsigned CTL_DATA_BIT  = 29;

  // clear word bit positions
  localparam int unsigned CLR_D2H_BIT   = 31;
  localparam int unsigned CLR_H2D_BIT   = 30;
  localparam int unsigned CLR_KIND_BIT  = 29;

  // interrupt slots
  localparam int unsigned N_IRQ   = 2;
  localparam int unsigned IRQ_H2D = 0;
  localparam int unsigned IRQ_D2H = 1;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/fisreg_axil.sv
module fisreg_axil #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              wr_fire,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_value
);
  import fisreg_pkg::*;

  logic              bvalid_q, bvalid_d;
  logic              rvalid_q, rvalid_d;
  logic [DATA_W-1:0] rdata_q,  rdata_d;
  logic              rd_fire;
  logic              b_free, r_free;

  assign b_free    = !bvalid_q || s_bready;
  assign r_free    = !rvalid_q || s_rready;
  assign wr_fire   = s_awvalid && s_wvalid && b_free;
  assign rd_fire   = s_arvalid && r_free;
  assign s_awready = wr_fire;
  assign s_wready  = wr_fire;
  assign s_arready = r_free;
  assign wr_addr   = s_awaddr;
  assign wr_data   = s_wdata;
  assign rd_addr   = s_araddr;

  always_comb begin
    bvalid_d = bvalid_q;
    rvalid_d = rvalid_q;
    rdata_d  = rdata_q;
    if (wr_fire)       bvalid_d = 1'b1;
    else if (s_bready) bvalid_d = 1'b0;
    if (rd_fire) begin
      rvalid_d = 1'b1;
      rdata_d  = rd_value;
    end else if (s_rready) begin
      rvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      bvalid_q <= bvalid_d;
      rvalid_q <= rvalid_d;
      if (rd_fire) rdata_q <= rdata_d;
    end
  end

  assign s_bvalid = bvalid_q;
  assign s_rvalid = rvalid_q;
  assign s_rdata  = rdata_q;
  assign s_bresp  = RESP_OKAY;
  assign s_rresp  = RESP_OKAY;

  // R12: a pending response is held until taken
  a_r12_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (s_bvalid && !s_bready) |=> s_bvalid);
  a_r12_r_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (s_rvalid && !s_rready) |=> (s_rvalid && $stable(s_rdata)));
endmodule

// File: rtl/fisreg_flag.sv
module fisreg_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_q, q_d;

  always_comb begin
    q_d = q_q;
    if (clr_i) q_d = 1'b0;
    if (set_i) q_d = 1'b1;   // set beats clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R9: a flag only rises after its done strobe
  a_r9_rise_needs_set: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_o) |-> $past(set_i));
  // R10: a strobe always leaves the flag set, clear or not
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
endmodule

// File: rtl/fis_dma_regbank.sv
module fis_dma_regbank #(
  parameter int unsigned ADDR_W     = 5,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ERR_W      = 8,
  parameter int unsigned CNT_W      = 24,
  parameter int unsigned WC_W       = 16,
  parameter int unsigned ALIGN_BITS = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic              s_bvalid,
  input  logic              s_bready,
  output logic [1:0]        s_bresp,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic [DATA_W-1:0] tx_addr_o,
  output logic [DATA_W-1:0] rx_fis_addr_o,
  output logic [DATA_W-1:0] rx_data_addr_o,
  output logic [WC_W-1:0]   tx_words_o,
  output logic              tx_is_data_o,
  output logic              start_o,
  output logic              dp_reset_o,
  output logic              irq_h2d_o,
  output logic              irq_d2h_o,
  input  logic              tx_done_i,
  input  logic              rx_done_i,
  input  logic              rx_nondata_i,
  input  logic              rx_word_i,
  input  logic              err_valid_i,
  input  logic [ERR_W-1:0]  err_code_i
);
  import fisreg_pkg::*;

  localparam int unsigned IDX_W = ADDR_W - 2;
  localparam logic [DATA_W-1:0] LOW_MASK =
    {{(DATA_W-ALIGN_BITS){1'b0}}, {ALIGN_BITS{1'b1}}};

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_l = rst_sync_q[1];

  // bus front end
  logic              wr_fire;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data, rd_value;

  fisreg_axil #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_axil (
    .clk(clk), .rst_n(rst_l),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
    .s_rresp(s_rresp),
    .wr_fire(wr_fire), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_value(rd_value)
  );

  // write decode
  logic             wr_ok;
  logic [IDX_W-1:0] wr_idx;
  logic             hit_tx, hit_rxf, hit_rxd, hit_ctrl, hit_clr, hit_addr;
  logic [DATA_W-1:0] addr_clean;
  logic             addr_bad;

  assign wr_ok      = wr_fire && (wr_addr[1:0] == 2'b00);
  assign wr_idx     = wr_addr[ADDR_W-1:2];
  assign hit_tx     = wr_ok && (wr_idx == IDX_W'(IDX_TX_ADDR));
  assign hit_rxf    = wr_ok && (wr_idx == IDX_W'(IDX_RX_FIS));
  assign hit_ctrl   = wr_ok && (wr_idx == IDX_W'(IDX_CTRL));
  assign hit_rxd    = wr_ok && (wr_idx == IDX_W'(IDX_RX_DATA));
  assign hit_clr    = wr_ok && (wr_idx == IDX_W'(IDX_CLEAR));
  assign hit_addr   = hit_tx || hit_rxf || hit_rxd;
  assign addr_clean = wr_data & ~LOW_MASK;
  assign addr_bad   = |(wr_data & LOW_MASK);

  // register state
  logic [DATA_W-1:0] tx_addr_q, rxf_addr_q, rxd_addr_q;
  logic [WC_W-1:0]   words_q;
  logic              is_data_q, start_q, dpr_q;
  logic [ERR_W-1:0]  err_q, err_d;
  logic              align_q, align_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              kind_q, kind_d;

  always_comb begin
    err_d = err_q;
    if (err_valid_i) err_d = err_code_i;

    align_d = align_q;
    if (hit_ctrl && wr_data[CTL_RESET_BIT]) align_d = 1'b0;
    if (hit_addr && addr_bad)               align_d = 1'b1;

    cnt_d = cnt_q;
    if (hit_ctrl)       cnt_d = '0;
    else if (rx_word_i) cnt_d = cnt_q + 1'b1;

    kind_d = kind_q;
    if (hit_clr && wr_data[CLR_KIND_BIT]) kind_d = 1'b0;
    if (rx_done_i)                        kind_d = rx_nondata_i;
  end

  always_ff @(posedge clk or negedge rst_l) begin
    if (!rst_l) begin
      tx_addr_q  <= '0;
      rxf_addr_q <= '0;
      rxd_addr_q <= '0;
      words_q    <= '0;
      is_data_q  <= 1'b0;
      start_q    <= 1'b0;
      dpr_q      <= 1'b0;
      err_q      <= '0;
      align_q    <= 1'b0;
      cnt_q      <= '0;
      kind_q     <= 1'b0;
    end else begin
      if (hit_tx)  tx_addr_q  <= addr_clean;
      if (hit_rxf) rxf_addr_q <= addr_clean;
      if (hit_rxd) rxd_addr_q <= addr_clean;
      if (hit_ctrl) begin
        words_q   <= wr_data[WC_W-1:0];
        is_data_q <= wr_data[CTL_DATA_BIT];
      end
      start_q <= hit_ctrl && wr_data[CTL_START_BIT];
      dpr_q   <= hit_ctrl && wr_data[CTL_RESET_BIT];
      err_q   <= err_d;
      align_q <= align_d;
      cnt_q   <= cnt_d;
      kind_q  <= kind_d;
    end
  end

  // interrupt flags
  logic [N_IRQ-1:0] irq_set, irq_clr, irq_q;
  assign irq_set[IRQ_H2D] = tx_done_i;
  assign irq_clr[IRQ_H2D] = hit_clr && wr_data[CLR_H2D_BIT];
  assign irq_set[IRQ_D2H] = rx_done_i;
  assign irq_clr[IRQ_D2H] = hit_clr && wr_data[CLR_D2H_BIT];

  for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
    fisreg_flag u_flag (
      .clk(clk), .rst_n(rst_l),
      .set_i(irq_set[g]), .clr_i(irq_clr[g]), .q_o(irq_q[g])
    );
  end

  // read map
  logic [IDX_W-1:0] rd_idx;
  assign rd_idx = rd_addr[ADDR_W-1:2];
  always_comb begin
    rd_value = '0;
    if (rd_addr[1:0] == 2'b00) begin
      if (rd_idx == IDX_W'(IDX_RD_ERR)) begin
        rd_value[ERR_W-1:0] = err_q;
        rd_value[ERR_W]     = align_q;
      end else if (rd_idx == IDX_W'(IDX_RD_COUNT)) begin
        rd_value[CNT_W-1:0]  = cnt_q;
        rd_value[DATA_W-1]   = kind_q;
      end
    end
  end

  assign tx_addr_o      = tx_addr_q;
  assign rx_fis_addr_o  = rxf_addr_q;
  assign rx_data_addr_o = rxd_addr_q;
  assign tx_words_o     = words_q;
  assign tx_is_data_o   = is_data_q;
  assign start_o        = start_q;
  assign dp_reset_o     = dpr_q;
  assign irq_h2d_o      = irq_q[IRQ_H2D];
  assign irq_d2h_o      = irq_q[IRQ_D2H];

  // R3: buffer bases never leave the 512-byte grid
  a_r3_tx_aligned: assert property (@(posedge clk) disable iff (!rst_l)
    tx_addr_o[ALIGN_BITS-1:0] == '0);
  a_r3_rx_aligned: assert property (@(posedge clk) disable iff (!rst_l)
    (rx_fis_addr_o[ALIGN_BITS-1:0] == '0) && (rx_data_addr_o[ALIGN_BITS-1:0] == '0));
  // R5: pulses never last two cycles
  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_l)
    start_o |=> !start_o);
  a_r5_reset_single: assert property (@(posedge clk) disable iff (!rst_l)
    dp_reset_o |=> !dp_reset_o);
  // R8: control write empties the word count
  a_r8_count_cleared: assert property (@(posedge clk) disable iff (!rst_l)
    hit_ctrl |=> (cnt_q == '0));
endmodule

// File: tb/test_fis_dma_regbank.sv
module test_fis_dma_regbank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  s_awaddr = '0, s_araddr = '0;
  logic        s_awvalid = 1'b0, s_wvalid = 1'b0, s_arvalid = 1'b0;
  logic [31:0] s_wdata = '0;
  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic        s_bready = 1'b1, s_rready = 1'b1;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [31:0] tx_addr, rxf_addr, rxd_addr;
  logic [15:0] tx_words;
  logic        tx_is_data, start, dp_reset, irq_h2d, irq_d2h;
  logic        tx_done = 1'b0, rx_done = 1'b0, rx_nondata = 1'b0, rx_word = 1'b0;
  logic        err_valid = 1'b0;
  logic [7:0]  err_code = '0;

  int checks = 0;
  int errors = 0;
  bit done_flag = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;   // 250 MHz

  fis_dma_regbank i_fis_dma_regbank (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(s_awaddr), .s_awvalid(s_awvalid), .s_awready(s_awready),
    .s_wdata(s_wdata), .s_wvalid(s_wvalid), .s_wready(s_wready),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_araddr(s_araddr), .s_arvalid(s_arvalid), .s_arready(s_arready),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
    .s_rresp(s_rresp),
    .tx_addr_o(tx_addr), .rx_fis_addr_o(rxf_addr), .rx_data_addr_o(rxd_addr),
    .tx_words_o(tx_words), .tx_is_data_o(tx_is_data),
    .start_o(start), .dp_reset_o(dp_reset),
    .irq_h2d_o(irq_h2d), .irq_d2h_o(irq_d2h),
    .tx_done_i(tx_done), .rx_done_i(rx_done), .rx_nondata_i(rx_nondata),
    .rx_word_i(rx_word), .err_valid_i(err_valid), .err_code_i(err_code)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // write; optional done strobes share the accepting edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d,
                    input logic txd = 1'b0, input logic rxd = 1'b0);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_awvalid = 1'b1; s_wvalid = 1'b1;
    tx_done = txd; rx_done = rxd;
    @(posedge clk);
    @(negedge clk);
    s_awvalid = 1'b0; s_wvalid = 1'b0; tx_done = 1'b0; rx_done = 1'b0;
    check("R12 bresp", {29'b0, s_bvalid, s_bresp}, 32'h4);
  endtask

  // read: push expectation, the monitor compares
  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s_arvalid = 1'b0;
  endtask

  task automatic strobe(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (which)
        0: tx_done = 1'b1;
        1: rx_done = 1'b1;
        default: rx_word = 1'b1;
      endcase
    end
    @(negedge clk);
    tx_done = 1'b0; rx_done = 1'b0; rx_word = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (s_rvalid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R12 unexpected read data: actual=%h expected=none", s_rdata);
      end else begin
        check(tag_q.pop_front(), {s_rdata[31:2], s_rdata[1:0] | {s_rresp != 2'b00, 1'b0}},
              exp_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 150000);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 addrs", tx_addr | rxf_addr | rxd_addr, 32'h0);
    check("R1 ctrl", {12'b0, tx_words, tx_is_data, start, dp_reset, irq_h2d, irq_d2h}, 32'h0);
    rd(5'h04, 32'h0, "R1 err reg");
    rd(5'h0C, 32'h0, "R1 count reg");

    // R2 address writes
    wr(5'h00, 32'h1000_0200);
    wr(5'h04, 32'h2000_0400);
    wr(5'h0C, 32'h3000_0600);
    check("R2 tx addr", tx_addr, 32'h1000_0200);
    check("R2 rx fis addr", rxf_addr, 32'h2000_0400);
    check("R2 rx data addr", rxd_addr, 32'h3000_0600);
    rd(5'h04, 32'h0, "R3 no align error on good addrs");

    // R3 misaligned
    wr(5'h00, 32'h0000_12FF);
    check("R3 forced low bits", tx_addr, 32'h0000_1200);
    wr(5'h0C, 32'h0000_4A00);
    check("R3 good addr after bad", rxd_addr, 32'h0000_4A00);
    rd(5'h04, 32'h0000_0100, "R3 sticky flag");

    // R6 error code latch
    @(negedge clk); err_valid = 1'b1; err_code = 8'h5A;
    @(negedge clk); err_valid = 1'b0; err_code = 8'hFF;
    rd(5'h04, 32'h0000_015A, "R6 err code and flag");

    // R4 / R5 control with start
    wr(5'h08, 32'h6000_0040);
    check("R5 start high", {30'b0, start, dp_reset}, 32'h2);
    check("R4 words", {15'b0, tx_is_data, tx_words}, 32'h0001_0040);
    @(negedge clk);
    check("R5 start one cycle", {30'b0, start, dp_reset}, 32'h0);

    // R5 reset pulse clears align flag (R3)
    wr(5'h08, 32'h8000_0000);
    check("R5 reset high", {30'b0, start, dp_reset}, 32'h1);
    @(negedge clk);
    check("R5 reset one cycle", {30'b0, start, dp_reset}, 32'h0);
    rd(5'h04, 32'h0000_005A, "R3 flag cleared by reset bit");

    // R7 count and kind, R9 rx irq
    strobe(2, 5);
    rx_nondata = 1'b1;
    strobe(1, 1);
    rx_nondata = 1'b0;
    check("R9 d2h irq set", {31'b0, irq_d2h}, 32'h1);
    rd(5'h0C, 32'h8000_0005, "R7 count and kind");

    // R11 kind clear leaves irqs
    wr(5'h10, 32'h2000_0000);
    check("R11 irq unchanged", {30'b0, irq_h2d, irq_d2h}, 32'h1);
    rd(5'h0C, 32'h0000_0005, "R11 kind cleared");

    // R8 control write clears count
    wr(5'h08, 32'h0000_0010);
    check("R4 other frame", {15'b0, tx_is_data, tx_words}, 32'h0000_0010);
    check("R8 no start", {30'b0, start, dp_reset}, 32'h0);
    rd(5'h0C, 32'h0, "R8 count cleared");

    // R9 h2d set/clear
    strobe(0, 1);
    check("R9 h2d set", {30'b0, irq_h2d, irq_d2h}, 32'h3);
    wr(5'h10, 32'h4000_0000);
    check("R9 h2d cleared only", {30'b0, irq_h2d, irq_d2h}, 32'h1);
    wr(5'h10, 32'h8000_0000);
    check("R9 d2h cleared", {30'b0, irq_h2d, irq_d2h}, 32'h0);

    // R10 done and clear same cycle
    wr(5'h10, 32'h4000_0000, 1'b1, 1'b0);
    check("R10 h2d wins", {30'b0, irq_h2d, irq_d2h}, 32'h2);
    wr(5'h10, 32'hC000_0000, 1'b0, 1'b1);
    check("R10 d2h wins", {30'b0, irq_h2d, irq_d2h}, 32'h1);

    // R12 unmapped read and misaligned write
    rd(5'h08, 32'h0, "R12 write-only offset reads zero");
    rd(5'h10, 32'h0, "R12 clear offset reads zero");
    wr(5'h01, 32'hABCD_E000);
    check("R12 misaligned write ignored", tx_addr, 32'h0000_1200);

    repeat (3) @(negedge clk);
    check("R12 all reads answered", exp_q.size(), 32'h0);
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule